// File: doc/BRIEF.md
# Level-Crossing Trigger Interrupt Generator

This block monitors a one-bit comparator result that reports whether an analog signal is above a trigger threshold. The bit arrives without any timing relationship to the clock. The block synchronizes it, detects its rising and falling transitions, and drives an active-low interrupt that lasts one clock at a chosen crossing. An interval counter runs from a start crossing to a stop crossing. When the count stops, a done flag is set and the count value is held.

Software first selects two things: the direction of the start crossing (upward or downward) and the measurement kind. In like-edge mode the stop is the next crossing in the same direction as the start, so the count gives one full period. Crossings in the other direction are suppressed. In opposite-edge mode that suppression is removed, so the stop is the next crossing in the other direction and the count gives a high time or a low time. Both selections are captured when the arm strobe is asserted. Each arm starts a new measurement.

Top module: `xing_irq_gen`

## Requirements
- R1: While reset is asserted, and after it until the first arm, `irq_n_o` is 1, `count_o` is 0 and `done_o` is 0.
- R2: `irq_n_o` is low for exactly one clock per measurement, in the same clock in which `done_o` first reads 1.
- R3: With like-edge mode (`special_i`=0) and upward start (`pol_neg_i`=0), a rising comparator edge starts the count and the next rising edge stops it. The falling edge between them causes no interrupt.
- R4: With like-edge mode and downward start (`pol_neg_i`=1), a falling edge starts the count and the next falling edge stops it. The rising edge between them is ignored.
- R5: With opposite-edge mode (`special_i`=1) and upward start, a rising edge starts the count and the next falling edge stops it.
- R6: With opposite-edge mode and downward start, a falling edge starts the count and the next rising edge stops it.
- R7: The final `count_o` equals the number of clocks between the start and stop transitions of the comparator. It holds that value while `done_o` is 1.
- R8: When no stop crossing arrives, the count stays at all-ones until the stop crossing comes.
- R9: `special_i` and `pol_neg_i` are sampled only in the clock where `arm_i` is 1. Changes at other times have no effect on the measurement in progress.
- R10: `arm_i` clears `done_o` in the next clock and restarts the wait for a start crossing, even in the middle of a measurement. `count_o` keeps its old value until the new start crossing.
- R11: Comparator transitions that occur while the block is not armed, or after a measurement has completed, cause no interrupt and do not change `count_o` or `done_o`.
- R12: `irq_n_o` falls on the third rising clock edge after the comparator transition that stops the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator result, not synchronized to the clock |
| special_i | input | 1 | 1 = opposite-edge stop, 0 = like-edge stop |
| pol_neg_i | input | 1 | 1 = start on a falling crossing, 0 = start on a rising crossing |
| arm_i | input | 1 | One-clock strobe that captures the mode and starts a measurement |
| irq_n_o | output | 1 | Interrupt, active low, one clock wide |
| count_o | output | CNT_W | Measured interval in clocks |
| done_o | output | 1 | Measurement complete; count is frozen |

## Verification
A wrong start state or a wrong edge gate shows at the ports as a count that is off by one half-cycle of the stimulus. It can also show as an interrupt at the intermediate crossing. Either is visible within three clocks of that crossing. A synchronizer stage too many or too few moves the falling edge of `irq_n_o` by one clock against the fixed three-clock latency. A missing saturation or a missing freeze corrupts `count_o` after the overflow point or after `done_o` is set. A stale configuration shows as a stop at the wrong edge after the mode inputs change while a measurement is running.

// File: rtl/xing_pkg.sv
package xing_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } xing_state_e;

   typedef struct packed {
      logic opp_edge;   // stop on the opposite-direction crossing
      logic down_start; // start on a falling crossing
   } xing_cfg_t;

   // crossing that begins a measurement
   function automatic logic start_sel(input xing_cfg_t c, input logic up, input logic dn);
      return c.down_start ? dn : up;
   endfunction

   // direction gate: open for the start direction, or always in opposite-edge mode
   function automatic logic dir_gate(input xing_cfg_t c, input logic up, input logic dn);
      return c.opp_edge | (c.down_start ? dn : up);
   endfunction

endpackage

// File: rtl/xing_sync_edge.sv
module xing_sync_edge #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic up_o,
   output logic dn_o
);
   localparam int unsigned DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_chk_stages
      $error("xing_sync_edge: STAGES must be at least 2");
   end

   logic [DEPTH-1:0] pipe;

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RESET_LVL;
            else        pipe[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RESET_LVL;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   logic lvl, lvl_d;
   assign lvl   = pipe[STAGES-1];
   assign lvl_d = pipe[STAGES];
   assign up_o  = lvl & ~lvl_d;
   assign dn_o  = ~lvl & lvl_d;

endmodule

// File: rtl/xing_ctrl.sv
module xing_ctrl
   import xing_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic special_i,
   input  logic pol_neg_i,
   input  logic up_i,
   input  logic dn_i,
   output logic start_o,
   output logic run_o,
   output logic irq_n_o,
   output logic done_o
);
   xing_state_e state_q;
   xing_cfg_t   cfg_q;
   logic        irq_n_q, done_q;
   logic        any_edge, stop_hit;

   assign any_edge = up_i | dn_i;
   // three-way qualification: edge pulse, direction gate, armed-and-started
   assign stop_hit = any_edge & dir_gate(cfg_q, up_i, dn_i) & (state_q == ST_RUN) & ~arm_i;
   assign start_o  = (state_q == ST_WAIT) & start_sel(cfg_q, up_i, dn_i) & ~arm_i;
   assign run_o    = (state_q == ST_RUN) & ~arm_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cfg_q   <= '0;
         irq_n_q <= 1'b1;
         done_q  <= 1'b0;
      end else if (arm_i) begin
         state_q <= ST_WAIT;
         cfg_q   <= '{opp_edge: special_i, down_start: pol_neg_i};
         irq_n_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         irq_n_q <= ~stop_hit;
         case (state_q)
            ST_WAIT: if (start_o) state_q <= ST_RUN;
            ST_RUN: begin
               if (stop_hit) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign irq_n_o = irq_n_q;
   assign done_o  = done_q;

endmodule

// File: rtl/xing_interval_ctr.sv
module xing_interval_ctr #(
   parameter int unsigned CNT_W    = 24,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             adv_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_chk_w
      $error("xing_interval_ctr: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, cnt_nxt;

   if (SATURATE) begin : g_sat
      assign cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
   end else begin : g_wrap
      assign cnt_nxt = cnt_q + CNT_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (adv_i)   cnt_q <= cnt_nxt;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/xing_irq_gen.sv
module xing_irq_gen #(
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_i,
   input  logic             special_i,
   input  logic             pol_neg_i,
   input  logic             arm_i,
   output logic             irq_n_o,
   output logic [CNT_W-1:0] count_o,
   output logic             done_o
);
   logic up_p, dn_p, start_p, run_p;

   xing_sync_edge #(.STAGES(SYNC_STAGES), .RESET_LVL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cmp_i),
      .up_o  (up_p),
      .dn_o  (dn_p)
   );

   xing_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (arm_i),
      .special_i (special_i),
      .pol_neg_i (pol_neg_i),
      .up_i      (up_p),
      .dn_i      (dn_p),
      .start_o   (start_p),
      .run_o     (run_p),
      .irq_n_o   (irq_n_o),
      .done_o    (done_o)
   );

   xing_interval_ctr #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_p),
      .adv_i   (run_p),
      .cnt_o   (count_o)
   );

endmodule

// File: rtl/xing_irq_gen_chk.sv
module xing_irq_gen_chk #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_i,
   input logic             irq_n_o,
   input logic [CNT_W-1:0] count_o,
   input logic             done_o
);
   localparam logic [CNT_W-1:0] ALL1 = '1;

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_n_o && !done_o && count_o == '0));

   assert_irq_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n_o |=> irq_n_o);

   assert_irq_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n_o) |-> $rose(done_o));

   assert_done_needs_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> !irq_n_o);

   assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> $stable(count_o));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == ALL1) |=> (count_o == ALL1 || count_o == '0));

   assert_arm_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> !done_o);

endmodule

bind xing_irq_gen xing_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .arm_i   (arm_i),
   .irq_n_o (irq_n_o),
   .count_o (count_o),
   .done_o  (done_o)
);

// File: tb/xing_irq_gen_tb.sv
module xing_irq_gen_tb;
   localparam int unsigned CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp = 1'b0, special = 1'b0, pol_neg = 1'b0, arm = 1'b0;
   logic irq_n, done;
   logic [CW-1:0] count;

   int checks = 0, fails = 0, lows = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   xing_irq_gen #(.CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .special_i(special),
      .pol_neg_i(pol_neg), .arm_i(arm), .irq_n_o(irq_n), .count_o(count), .done_o(done)
   );

   always @(negedge clk) if (rst_n && !irq_n) lows++;

   typedef struct packed {
      logic       sp;
      logic       ng;
      logic [7:0] l1;
      logic [7:0] l2;
      logic [8:0] exp;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b0, 1'b0, 8'd5,  8'd7, 9'd12},
      '{1'b0, 1'b1, 8'd4,  8'd9, 9'd13},
      '{1'b1, 1'b0, 8'd6,  8'd3, 9'd6},
      '{1'b1, 1'b1, 8'd10, 8'd2, 9'd10},
      '{1'b0, 1'b0, 8'd3,  8'd3, 9'd6},
      '{1'b1, 1'b1, 8'd1,  8'd1, 9'd1}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic arm_pulse(input logic sp, input logic ng);
      special = sp; pol_neg = ng; arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int base;
      // R1: reset state
      tick(4);
      chk("R1 irq_n", irq_n, 1);
      chk("R1 count", count, 0);
      chk("R1 done", done, 0);
      rst_n = 1'b1;
      // R11: transitions before any arm
      for (int k = 0; k < 6; k++) begin cmp = ~cmp; tick(3); end
      tick(4);
      chk("R11 irq before arm", lows, 0);
      chk("R11 done before arm", done, 0);
      chk("R1 count after release", count, 0);

      // table walk: R3..R7, R11
      for (int i = 0; i < 6; i++) begin
         string tag;
         tag = VEC[i].sp ? (VEC[i].ng ? "R6" : "R5") : (VEC[i].ng ? "R4" : "R3");
         cmp = VEC[i].ng;
         tick(6);
         arm_pulse(VEC[i].sp, VEC[i].ng);
         tick(2);
         base = lows;
         cmp = ~cmp; tick(int'(VEC[i].l1));
         cmp = ~cmp; tick(int'(VEC[i].l2));
         cmp = ~cmp; tick(int'(VEC[i].l1));
         cmp = ~cmp; tick(10);
         chk({tag, " R7 count"}, count, VEC[i].exp);
         chk({tag, " done"}, done, 1);
         chk({tag, " R2 R11 single irq"}, lows - base, 1);
      end

      // R12: latency of the interrupt from the stop transition
      cmp = 1'b0; tick(6);
      arm_pulse(1'b0, 1'b0); tick(2);
      cmp = 1'b1; tick(4);
      cmp = 1'b0; tick(4);
      cmp = 1'b1;
      tick(2);
      chk("R12 irq still high after 2 edges", irq_n, 1);
      tick(1);
      chk("R12 irq low after 3 edges", irq_n, 0);
      tick(1);
      chk("R2 irq back high", irq_n, 1);
      chk("R7 latency count", count, 8);

      // R8: saturation
      cmp = 1'b0; tick(6);
      arm_pulse(1'b0, 1'b0); tick(2);
      cmp = 1'b1; tick(200);
      cmp = 1'b0; tick(100);
      cmp = 1'b1; tick(8);
      chk("R8 saturated count", count, 255);
      chk("R8 done", done, 1);

      // R9: mode inputs changed after arm are ignored
      cmp = 1'b0; tick(6);
      arm_pulse(1'b0, 1'b0);
      special = 1'b1; pol_neg = 1'b1;
      tick(2);
      base = lows;
      cmp = 1'b1; tick(5);
      cmp = 1'b0; tick(6);
      cmp = 1'b1; tick(8);
      chk("R9 count uses armed config", count, 11);
      chk("R9 single irq", lows - base, 1);

      // R10: re-arm clears done, holds count, restarts mid-measurement
      arm_pulse(1'b0, 1'b0);
      tick(2);
      chk("R10 done cleared", done, 0);
      chk("R10 count held", count, 11);
      base = lows;
      cmp = 1'b0; tick(3);
      cmp = 1'b1; tick(3);            // start, measurement running
      arm_pulse(1'b1, 1'b0); tick(2); // restart, opposite-edge, upward start
      cmp = 1'b0; tick(3);            // falling edge ignored while waiting
      cmp = 1'b1; tick(7);            // start
      cmp = 1'b0; tick(8);            // stop
      chk("R10 count after restart", count, 7);
      chk("R10 done", done, 1);
      chk("R10 one irq", lows - base, 1);

      finish_run();
   end
endmodule